// File: doc/BRIEF.md
# Word FIFO to Byte Port Transfer Engine

This block sits between a host-facing word FIFO of 16 entries by 32 bits and a byte-wide card data port. It carries data in either direction for one programmed transfer at a time. When the block receives, it collects bytes arriving from the card and packs them into words that the host then pops. When it transmits, it takes words the host has pushed and hands their bytes to the card one at a time. A 16-bit byte counter, loaded when a transfer starts, sets the length of each transfer. A final partial word is handled in both directions.

The host starts a transfer by pulsing a control strobe with the enable bit set, the direction bit and the length. The block reports FIFO occupancy flags for the active direction only. It also reports two end-of-transfer flags, and it drops its enable by itself once the count has reached zero and the FIFO has drained. The engine moves at most one byte per clock.

Top module: `bytelane_fifo_engine`

## Requirements
- R1: After synchronous reset, xfer_en, byte_cnt, data_end, blk_end, rx_ready, tx_valid and every occupancy flag read 0.
- R2: A cycle with ctl_wr=1 and ctl_en=1 has the following effects from the next cycle. byte_cnt takes ctl_len. The direction ctl_dir is latched (1 = receive from card into FIFO, 0 = transmit from FIFO to card). xfer_en reads 1, and data_end/blk_end read 0. A cycle with ctl_wr=1 and ctl_en=0 clears xfer_en without changing byte_cnt.
- R3: When receiving, the bytes of each group of four are placed into a word in arrival order: the first byte in bits 7:0, then 15:8, then 23:16, then 31:24. The word enters the FIFO on the fourth byte.
- R4: When receiving, if byte_cnt reaches zero partway through a word, that partial word enters the FIFO, with its unfilled upper bytes set to zero.
- R5: When transmitting, each popped word is sent least-significant byte first. The next word is taken only after four bytes have gone out. If byte_cnt reaches zero first, the remaining bytes of the word are dropped.
- R6: byte_cnt decreases by exactly one for each byte handshake (rx_valid&rx_ready or tx_valid&tx_ready) and is otherwise unchanged. At most one byte moves per clock, and none moves while byte_cnt is 0.
- R7: rx_ready stays low while card_rdy is low or while the FIFO holds 16 words.
- R8: While xfer_en=1 and byte_cnt=0, data_end and blk_end both read 1 from the next cycle. They stay set until the next start.
- R9: When byte_cnt=0 and the FIFO is empty, every occupancy flag reads 0 in that same cycle, and xfer_en reads 0 from the next cycle.
- R10: While a transfer is live, the occupancy flags follow the FIFO level: empty at 0, avail above 0, full at 16, rx_half_full at 8 or more, tx_half_empty at 8 or fewer. Only the rx_* set (with rx_act) is driven when receiving, and only the tx_* set (with tx_act) when transmitting.
- R11: A host push is accepted only while transmitting with byte_cnt nonzero and the FIFO not full; otherwise it is ignored. A host pop is honoured only while receiving with the FIFO nonempty, and its word appears on host_rdata the next cycle. Any other pop makes host_rdata read 0.
- R12: A start with ctl_len=0 raises data_end and blk_end and clears xfer_en one cycle after the start, with no byte moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable value written with ctl_wr (1 starts a transfer, 0 stops it) |
| ctl_dir | input | 1 | Direction written with a start: 1 receive, 0 transmit |
| ctl_len | input | 16 | Transfer length in bytes, loaded on a start |
| host_push | input | 1 | Host word push request |
| host_wdata | input | 32 | Host word to push |
| host_pop | input | 1 | Host word pop request |
| host_rdata | output | 32 | Popped word, valid the cycle after host_pop |
| card_rdy | input | 1 | Card has receive data ready |
| rx_valid | input | 1 | Card byte valid |
| rx_byte | input | 8 | Card byte |
| rx_ready | output | 1 | Engine accepts the card byte |
| tx_valid | output | 1 | Engine offers a byte to the card |
| tx_byte | output | 8 | Byte to the card |
| tx_ready | input | 1 | Card accepts the byte |
| xfer_en | output | 1 | Transfer enable state |
| byte_cnt | output | 16 | Remaining byte count |
| data_end | output | 1 | End-of-data flag |
| blk_end | output | 1 | End-of-block flag |
| rx_act | output | 1 | Receive transfer live |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_avail | output | 1 | Receive FIFO holds data |
| rx_half_full | output | 1 | Receive FIFO at least half full |
| rx_full | output | 1 | Receive FIFO full |
| tx_act | output | 1 | Transmit transfer live |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_avail | output | 1 | Transmit FIFO holds data |
| tx_half_empty | output | 1 | Transmit FIFO at most half full |
| tx_full | output | 1 | Transmit FIFO full |

## Verification
The bench targets byte order at word edges: a design with swapped lanes would produce words in reverse byte order or send a word most-significant byte first. It also covers lengths that are not a multiple of four. Here a wrong design would leave stale upper bytes in the last received word, or send bytes beyond the count. The bench fills the receive FIFO to exactly 16 words, where a wrong full check would overwrite data, and walks the half-level thresholds at 7, 8 and 9 words. It also exercises a zero-length start, a stop write, and host pushes or pops in the wrong direction. A design that got these wrong would hang with the enable set, or let ignored traffic corrupt the FIFO.

// File: rtl/bfe_pkg.sv
package bfe_pkg;

  // Transfer direction latched at the start of a transfer.
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;

  // Occupancy flags for one direction.
  typedef struct packed {
    logic act;
    logic empty;
    logic avail;
    logic half;
    logic full;
  } side_flags_t;

endpackage

// File: rtl/bfe_word_fifo.sv
module bfe_word_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign level   = cnt_q;

  // Storage without reset so a block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
    if (do_pop)  rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/bfe_rx_packer.sv
module bfe_rx_packer #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic              last,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              push,
  output logic [WORD_W-1:0] word
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LW-1:0]     lane_q;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] merged;

  // Each lane takes the incoming byte when it is the current lane.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*BYTE_W +: BYTE_W] =
      (take && lane_q == LW'(i)) ? byte_in : acc_q[i*BYTE_W +: BYTE_W];
  end

  assign push = take && ((lane_q == LW'(LANES - 1)) || last);
  assign word = merged;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else if (take) begin
      if (push) begin
        lane_q <= '0;
        acc_q  <= '0;
      end else begin
        lane_q <= lane_q + LW'(1);
        acc_q  <= merged;
      end
    end
  end
endmodule

// File: rtl/bfe_tx_unpacker.sv
module bfe_tx_unpacker #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_rdata,
  input  logic              sent,
  input  logic              last,
  output logic              pop,
  output logic              have,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int NW    = $clog2(LANES + 1);

  logic [NW-1:0]     left_q;
  logic              wait_q;
  logic [WORD_W-1:0] word_q;

  assign pop      = run && (left_q == '0) && !wait_q && !fifo_empty;
  assign have     = (left_q != '0);
  assign byte_out = word_q[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      left_q <= '0;
      wait_q <= 1'b0;
      word_q <= '0;
    end else begin
      wait_q <= pop;
      if (wait_q) begin
        word_q <= fifo_rdata;
        left_q <= NW'(LANES);
      end else if (sent) begin
        word_q <= word_q >> BYTE_W;
        left_q <= last ? '0 : left_q - NW'(1);
      end
    end
  end
endmodule

// File: rtl/bfe_status_flags.sv
module bfe_status_flags
  import bfe_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          en,
  input  dir_e          dir,
  input  logic          cnt_zero,
  input  logic [CW-1:0] level,
  output side_flags_t   rx_f,
  output side_flags_t   tx_f
);
  localparam int HALF = DEPTH / 2;

  logic        live;
  side_flags_t base_rx, base_tx;

  always_comb begin
    live          = en && !(cnt_zero && level == '0);
    base_rx.act   = 1'b1;
    base_rx.empty = (level == '0);
    base_rx.avail = (level != '0);
    base_rx.full  = (level == CW'(DEPTH));
    base_rx.half  = (level >= CW'(HALF));
    base_tx       = base_rx;
    base_tx.half  = (level <= CW'(HALF));
    rx_f = (live && dir == DIR_RX) ? base_rx : '0;
    tx_f = (live && dir == DIR_TX) ? base_tx : '0;
  end
endmodule

// File: rtl/bytelane_fifo_engine.sv
module bytelane_fifo_engine
  import bfe_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              ctl_en,
  input  logic              ctl_dir,
  input  logic [LEN_W-1:0]  ctl_len,
  input  logic              host_push,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              host_pop,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              card_rdy,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_ready,
  output logic              xfer_en,
  output logic [LEN_W-1:0]  byte_cnt,
  output logic              data_end,
  output logic              blk_end,
  output logic              rx_act,
  output logic              rx_empty,
  output logic              rx_avail,
  output logic              rx_half_full,
  output logic              rx_full,
  output logic              tx_act,
  output logic              tx_empty,
  output logic              tx_avail,
  output logic              tx_half_empty,
  output logic              tx_full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic             en_q, done_q, zero_q;
  dir_e             dir_q;
  logic [LEN_W-1:0] cnt_q;

  logic              start, stop, cnt_zero;
  logic              rx_take, tx_sent, step;
  logic              pk_push, up_pop, up_have;
  logic [WORD_W-1:0] pk_word;
  logic              host_push_ok, host_pop_ok;
  logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [WORD_W-1:0] fifo_wdata, fifo_rdata;
  logic [CW-1:0]     fifo_level;
  side_flags_t       rx_f, tx_f;

  assign start    = ctl_wr && ctl_en;
  assign stop     = ctl_wr && !ctl_en;
  assign cnt_zero = (cnt_q == '0);

  // Card side handshakes.
  assign rx_ready = en_q && (dir_q == DIR_RX) && !cnt_zero && card_rdy && !fifo_full;
  assign rx_take  = rx_ready && rx_valid;
  assign tx_valid = en_q && (dir_q == DIR_TX) && !cnt_zero && up_have;
  assign tx_sent  = tx_valid && tx_ready;
  assign step     = rx_take || tx_sent;

  // Host side gating.
  assign host_push_ok = host_push && en_q && (dir_q == DIR_TX) && !cnt_zero && !fifo_full;
  assign host_pop_ok  = host_pop && (dir_q == DIR_RX) && !fifo_empty;

  assign fifo_push  = pk_push || host_push_ok;
  assign fifo_wdata = pk_push ? pk_word : host_wdata;
  assign fifo_pop   = up_pop || host_pop_ok;

  bfe_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (fifo_push),
    .wdata (fifo_wdata),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .level (fifo_level),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  bfe_rx_packer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pack (
    .clk     (clk),
    .rst     (rst),
    .clr     (start),
    .take    (rx_take),
    .last    (cnt_q == LEN_W'(1)),
    .byte_in (rx_byte),
    .push    (pk_push),
    .word    (pk_word)
  );

  bfe_tx_unpacker #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_unpack (
    .clk        (clk),
    .rst        (rst),
    .clr        (start),
    .run        (en_q && (dir_q == DIR_TX) && !cnt_zero),
    .fifo_empty (fifo_empty),
    .fifo_rdata (fifo_rdata),
    .sent       (tx_sent),
    .last       (cnt_q == LEN_W'(1)),
    .pop        (up_pop),
    .have       (up_have),
    .byte_out   (tx_byte)
  );

  bfe_status_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .en       (en_q),
    .dir      (dir_q),
    .cnt_zero (cnt_zero),
    .level    (fifo_level),
    .rx_f     (rx_f),
    .tx_f     (tx_f)
  );

  // Transfer control registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      dir_q  <= DIR_TX;
      cnt_q  <= '0;
      done_q <= 1'b0;
      zero_q <= 1'b1;
    end else begin
      if (host_pop) zero_q <= !host_pop_ok;
      if (start) begin
        en_q   <= 1'b1;
        dir_q  <= dir_e'(ctl_dir);
        cnt_q  <= ctl_len;
        done_q <= 1'b0;
      end else begin
        if (stop)                               en_q <= 1'b0;
        else if (en_q && cnt_zero && fifo_empty) en_q <= 1'b0;
        if (step)             cnt_q  <= cnt_q - LEN_W'(1);
        if (en_q && cnt_zero) done_q <= 1'b1;
      end
    end
  end

  assign host_rdata    = zero_q ? '0 : fifo_rdata;
  assign xfer_en       = en_q;
  assign byte_cnt      = cnt_q;
  assign data_end      = done_q;
  assign blk_end       = done_q;
  assign rx_act        = rx_f.act;
  assign rx_empty      = rx_f.empty;
  assign rx_avail      = rx_f.avail;
  assign rx_half_full  = rx_f.half;
  assign rx_full       = rx_f.full;
  assign tx_act        = tx_f.act;
  assign tx_empty      = tx_f.empty;
  assign tx_avail      = tx_f.avail;
  assign tx_half_empty = tx_f.half;
  assign tx_full       = tx_f.full;
endmodule

// File: rtl/bfe_checker.sv
module bfe_checker #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_wr,
  input logic             ctl_en,
  input logic [LEN_W-1:0] ctl_len,
  input logic             card_rdy,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             xfer_en,
  input logic [LEN_W-1:0] byte_cnt,
  input logic             data_end,
  input logic             rx_act,
  input logic             rx_empty,
  input logic             rx_avail,
  input logic             rx_half_full,
  input logic             rx_full,
  input logic             tx_act,
  input logic             tx_empty,
  input logic             tx_avail,
  input logic             tx_half_empty,
  input logic             tx_full,
  input logic [CW-1:0]    fifo_lvl
);
  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_en) |=> (xfer_en && byte_cnt == $past(ctl_len))); // R2
  AST_RX_STEP: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready && !ctl_wr) |=> (byte_cnt == $past(byte_cnt) - LEN_W'(1))); // R6
  AST_TX_STEP: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !ctl_wr) |=> (byte_cnt == $past(byte_cnt) - LEN_W'(1))); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(rx_valid && rx_ready) && !(tx_valid && tx_ready) && !ctl_wr) |=> $stable(byte_cnt)); // R6
  AST_NO_MOVE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (byte_cnt == '0) |-> !(rx_ready || tx_valid)); // R6
  AST_RX_STALL: assert property (@(posedge clk) disable iff (rst)
    (!card_rdy || rx_full) |-> !rx_ready); // R7
  AST_END_HOLD: assert property (@(posedge clk) disable iff (rst)
    (data_end && !(ctl_wr && ctl_en)) |=> data_end); // R8
  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && byte_cnt == '0 && fifo_lvl == '0 && !ctl_wr) |=> (!xfer_en && data_end)); // R9
  AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !xfer_en |-> !(rx_act || rx_empty || rx_avail || rx_half_full || rx_full ||
                   tx_act || tx_empty || tx_avail || tx_half_empty || tx_full)); // R9
  AST_DIR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_act, tx_act})); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fifo_lvl <= CW'(DEPTH)); // R11
endmodule

bind bytelane_fifo_engine bfe_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CW(CW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ctl_wr        (ctl_wr),
  .ctl_en        (ctl_en),
  .ctl_len       (ctl_len),
  .card_rdy      (card_rdy),
  .rx_valid      (rx_valid),
  .rx_ready      (rx_ready),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .xfer_en       (xfer_en),
  .byte_cnt      (byte_cnt),
  .data_end      (data_end),
  .rx_act        (rx_act),
  .rx_empty      (rx_empty),
  .rx_avail      (rx_avail),
  .rx_half_full  (rx_half_full),
  .rx_full       (rx_full),
  .tx_act        (tx_act),
  .tx_empty      (tx_empty),
  .tx_avail      (tx_avail),
  .tx_half_empty (tx_half_empty),
  .tx_full       (tx_full),
  .fifo_lvl      (fifo_level)
);

// File: tb/tb_bytelane_fifo_engine.sv
`timescale 1ns/1ps
module tb_bytelane_fifo_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 0, ctl_en = 0, ctl_dir = 0;
  logic [15:0] ctl_len = '0;
  logic        host_push = 0, host_pop = 0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        card_rdy = 0, rx_valid = 0, tx_ready = 0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready, tx_valid;
  logic [7:0]  tx_byte;
  logic        xfer_en, data_end, blk_end;
  logic [15:0] byte_cnt;
  logic rx_act, rx_empty, rx_avail, rx_half_full, rx_full;
  logic tx_act, tx_empty, tx_avail, tx_half_empty, tx_full;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bytelane_fifo_engine dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start(input logic dir, input logic [15:0] len);
    ctl_wr = 1; ctl_en = 1; ctl_dir = dir; ctl_len = len;
    @(negedge clk);
    ctl_wr = 0; ctl_en = 0;
    #1;
  endtask

  task automatic push(input logic [31:0] w);
    host_push = 1; host_wdata = w;
    @(negedge clk);
    host_push = 0;
  endtask

  task automatic pop_expect(input string tag, input logic [31:0] exp);
    host_pop = 1;
    @(negedge clk);
    host_pop = 0;
    #1;
    chk(tag, host_rdata, exp);
  endtask

  task automatic feed(input logic [7:0] b);
    int guard = 0;
    rx_valid = 1; rx_byte = b; card_rdy = 1;
    #1;
    while (!rx_ready && guard < 40) begin
      @(negedge clk); #1; guard++;
    end
    @(negedge clk);
    rx_valid = 0;
    if (guard >= 40) chk("R7 receive stuck", 32'd0, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 xfer_en", xfer_en, 0);
    chk("R1 byte_cnt", byte_cnt, 0);
    chk("R1 end flags", {data_end, blk_end}, 0);
    chk("R1 handshakes", {rx_ready, tx_valid}, 0);
    chk("R1 flags", {rx_act, rx_empty, rx_avail, rx_half_full, rx_full,
                     tx_act, tx_empty, tx_avail, tx_half_empty, tx_full}, 0);
  endtask

  task automatic t_rx_partial();
    start(1, 16'd6);
    chk("R2 load count", byte_cnt, 6);
    chk("R2 enable set", xfer_en, 1);
    feed(8'hAA); feed(8'hBB); feed(8'hCC); feed(8'hDD); feed(8'hEE); feed(8'hFF);
    #1;
    chk("R6 count at zero", byte_cnt, 0);
    pop_expect("R3 packed word", 32'hDDCCBBAA);
    pop_expect("R4 partial word", 32'h0000FFEE);
    @(negedge clk); #1;
    chk("R9 enable cleared", xfer_en, 0);
    chk("R8 end flags", {data_end, blk_end}, 2'b11);
  endtask

  task automatic t_rx_fill();
    start(1, 16'd68);
    chk("R10 rx start flags", {rx_act, rx_empty, rx_avail, rx_half_full, tx_act}, 5'b11000);
    chk("R8 end flags cleared by start", {data_end, blk_end}, 0);
    for (int k = 0; k < 64; k++) begin
      if (k == 28) begin #1; chk("R10 rx half at 7", rx_half_full, 0); end
      if (k == 32) begin #1; chk("R10 rx half at 8", rx_half_full, 1); end
      feed(8'(k));
    end
    rx_valid = 1; card_rdy = 1;
    #1;
    chk("R10 rx full", {rx_full, rx_half_full, rx_avail, rx_empty}, 4'b1110);
    chk("R7 stall on full", rx_ready, 0);
    @(negedge clk); @(negedge clk); #1;
    chk("R6 count holds on stall", byte_cnt, 4);
    rx_valid = 0;
    pop_expect("R3 first word", 32'h03020100);
    for (int k = 64; k < 68; k++) feed(8'(k));
    for (int w = 1; w < 17; w++)
      pop_expect("R3 word order", {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
    @(negedge clk); #1;
    chk("R9 rx enable cleared", xfer_en, 0);
  endtask

  task automatic t_ignored();
    logic [7:0] b;
    start(1, 16'd4);
    push(32'hDEADBEEF);
    #1;
    chk("R11 push ignored in receive", {rx_empty, rx_avail}, 2'b10);
    pop_expect("R11 pop on empty reads zero", 32'h0);
    card_rdy = 0; rx_valid = 1;
    #1;
    chk("R7 stall without card ready", rx_ready, 0);
    @(negedge clk); @(negedge clk); #1;
    chk("R7 count unchanged", byte_cnt, 4);
    rx_valid = 0;
    for (int k = 1; k <= 4; k++) begin b = 8'(k); feed(b); end
    pop_expect("R11 pop honoured", 32'h04030201);
    @(negedge clk); #1;
    chk("R9 enable cleared", xfer_en, 0);
  endtask

  task automatic t_tx_short();
    logic [7:0] got[$];
    logic [7:0] exp[6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    int guard = 0;
    tx_ready = 0;
    start(0, 16'd6);
    chk("R10 tx start flags", {tx_act, tx_empty, tx_avail, tx_half_empty, rx_act}, 5'b11010);
    push(32'h44332211);
    push(32'h88776655);
    tx_ready = 1;
    while (got.size() < 6 && guard < 100) begin
      #1;
      if (tx_valid) got.push_back(tx_byte);
      @(negedge clk);
      guard++;
    end
    chk("R5 byte count", got.size(), 6);
    for (int i = 0; i < 6 && i < got.size(); i++) chk("R5 byte order", got[i], exp[i]);
    @(negedge clk); @(negedge clk); #1;
    chk("R5 tail dropped", tx_valid, 0);
    chk("R9 tx enable cleared", xfer_en, 0);
    chk("R8 tx end flags", {data_end, blk_end}, 2'b11);
    chk("R9 tx flags clear", {tx_act, tx_empty, tx_avail, tx_half_empty, tx_full}, 0);
    tx_ready = 0;
  endtask

  task automatic t_tx_long();
    logic [7:0] got[$];
    int guard = 0;
    tx_ready = 0;
    start(0, 16'd40);
    for (int w = 0; w < 10; w++)
      push({8'((4*w+3)*3+5), 8'((4*w+2)*3+5), 8'((4*w+1)*3+5), 8'((4*w)*3+5)});
    @(negedge clk); @(negedge clk); @(negedge clk); #1;
    chk("R10 tx level 9", {tx_half_empty, tx_avail, tx_full, tx_empty}, 4'b0100);
    tx_ready = 1;
    while (got.size() < 40 && guard < 200) begin
      #1;
      if (tx_valid) got.push_back(tx_byte);
      @(negedge clk);
      guard++;
    end
    chk("R6 tx byte total", got.size(), 40);
    for (int k = 0; k < 40 && k < got.size(); k++) chk("R5 long byte order", got[k], 8'(k*3+5));
    @(negedge clk); @(negedge clk); #1;
    chk("R6 tx count zero", byte_cnt, 0);
    chk("R9 tx long done", xfer_en, 0);
    tx_ready = 0;
  endtask

  task automatic t_zero_len();
    start(1, 16'd0);
    chk("R12 enable after start", xfer_en, 1);
    chk("R9 flags off at zero", {rx_act, rx_empty, rx_avail}, 0);
    chk("R8 end flags cleared", data_end, 0);
    @(negedge clk); #1;
    chk("R12 enable cleared", xfer_en, 0);
    chk("R12 end flags", {data_end, blk_end}, 2'b11);
  endtask

  task automatic t_stop();
    start(0, 16'd8);
    chk("R2 tx live", tx_act, 1);
    ctl_wr = 1; ctl_en = 0;
    @(negedge clk);
    ctl_wr = 0;
    #1;
    chk("R2 stop clears enable", xfer_en, 0);
    chk("R2 stop keeps count", byte_cnt, 8);
    chk("R2 stop flags", {tx_act, tx_empty, data_end}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    t_reset();
    t_rx_partial();
    t_rx_fill();
    t_ignored();
    t_tx_short();
    t_tx_long();
    t_zero_len();
    t_stop();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule